// File: doc/BRIEF.md
# SPI Clock-Calendar Register Access Target

This block is the serial front end of a small clock-calendar device. A host reaches a file of sixteen 8-bit registers over a four-wire SPI link. The select line is active high, and the link runs in mode 1: the clock idles low, the target changes its output after each rising edge, and it samples the host's data on each falling edge. Bits travel most significant first. All link signals pass through synchronisers and are oversampled by the block clock. The SCLK half period must be at least 6 block-clock cycles, and select must rise at least 4 block-clock cycles before the first SCLK edge.

The first byte of each selection is a command. Its high nibble names a register. Bit 3 of its low nibble chooses single (1) or burst (0) access, and bit 2 chooses read (1) or write (0). The block turns the bytes that follow into one-cycle read and write strobes on a plain register port. The timekeeping counters sit behind that port. In burst access the address steps up after every data byte and wraps from 15 to 0. Register 0 holds seconds. Its top bit always reads back as 0, so a host can use it to check that the device is present.

Top module: `spi_rtc_target`

## Requirements
- R1: While the synchronised select is low, miso_oe_o and miso_o are 0 and no register strobe is issued.
- R2: Read data leaves MSB first. Each bit changes after a rising SCLK edge and is valid at the following falling edge. Host data is sampled on falling edges.
- R3: The command byte carries the address in bits [7:4]. Bit 3 = 1 selects single and 0 selects burst. Bit 2 = 1 selects read and 0 selects write. Bits [1:0] are ignored. The mode nibbles are 0x8 for single write, 0xC for single read, 0x0 for burst write and 0x4 for burst read.
- R4: A single write issues exactly one write strobe, carrying the commanded address and the first data byte. Any further bytes in that selection cause no strobe.
- R5: A single read returns the commanded register in the byte after the command. Any further bytes in that selection read 0x00.
- R6: A burst write stores successive data bytes at successive addresses, starting at the commanded address and wrapping from 15 to 0.
- R7: A burst read returns successive registers, starting at the commanded address and wrapping from 15 to 0.
- R8: Bit 7 of register 0 always reads as 0 over the link.
- R9: A write strobe is issued only after all 8 bits of a data byte have arrived. Dropping select at any point abandons the transaction. The next selection starts again with a fresh command byte.
- R10: Each register read is a one-cycle reg_rd_o pulse with the address on reg_addr_o, and reg_rdata_i is taken in that same cycle.
- R11: The target drives 0 on miso_o during the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for miso_o |
| reg_addr_o | output | 4 | Register port address |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid in the reg_rd_o cycle |

## Verification
The bench aims at the address wrap from 15 to 0 in both burst directions. A design with a wrong counter would write to or return the wrong register after address 15. It cuts select part-way through a data byte and part-way through a command. A design that commits early or keeps stale command state would then show a spurious write strobe or would misread the next command. It also sends bytes past the end of a single-access transaction and uses a command with nonzero low bits. A design that kept stepping the address would emit extra strobes or non-zero read bytes, and a design that decoded the low bits would pick the wrong mode. A seconds register preloaded with its top bit set shows whether that bit is masked on every read path.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned SINGLE_B = 3;
  localparam int unsigned READ_B   = 2;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_DATA,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/spi_rtc_sync.sv
module spi_rtc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rtc_shifter.sv
module spi_rtc_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          miso_o
);
  localparam int unsigned CW = $clog2(DW);

  logic          sclk_d;
  logic          rise, fall;
  logic [CW-1:0] cnt_q;
  logic [DW-2:0] rx_q;
  logic [DW-1:0] tx_q;
  logic          miso_q;

  assign rise = cs_i & sclk_i & ~sclk_d;
  assign fall = cs_i & ~sclk_i & sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      miso_q     <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      sclk_d     <= sclk_i;
      byte_vld_o <= 1'b0;
      if (!cs_i) begin
        cnt_q  <= '0;
        rx_q   <= '0;
        tx_q   <= '0;
        miso_q <= 1'b0;
      end else begin
        // mode 1: drive on rise, sample on fall
        if (load_i) begin
          tx_q <= load_data_i;
        end else if (rise) begin
          miso_q <= tx_q[DW-1];
          tx_q   <= {tx_q[DW-2:0], 1'b0};
        end
        if (fall) begin
          rx_q  <= {rx_q[DW-3:0], mosi_i};
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(DW-1)) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {rx_q, mosi_i};
          end
        end
      end
    end
  end

  assign miso_o = miso_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (cnt_q == '0)) else $error("bit count not cleared"); // R9
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o) else $error("byte valid held"); // R4
endmodule

// File: rtl/spi_rtc_cmd.sv
module spi_rtc_cmd
  import spi_rtc_pkg::*;
#(
  parameter int unsigned          AW       = ADDR_W,
  parameter int unsigned          DW       = BYTE_W,
  parameter logic [ADDR_W-1:0]    SEC_ADDR = '0,
  parameter logic [BYTE_W-1:0]    SEC_MASK = 8'h7f
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_rd_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          load_o,
  output logic [DW-1:0] load_data_o
);
  phase_e        phase_q;
  logic [AW-1:0] addr_q;
  logic          single_q, read_q, wr_q, rd_q;
  logic [DW-1:0] wdata_q;
  logic          unused_mode;

  assign unused_mode = ^byte_i[READ_B-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      addr_q   <= '0;
      single_q <= 1'b0;
      read_q   <= 1'b0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      wdata_q  <= '0;
    end else if (!cs_i) begin
      phase_q <= PH_CMD;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (wr_q && !single_q) addr_q <= addr_q + AW'(1);
      if (byte_vld_i) begin
        unique case (phase_q)
          PH_CMD: begin
            addr_q   <= byte_i[DW-1 -: AW];
            single_q <= byte_i[SINGLE_B];
            read_q   <= byte_i[READ_B];
            rd_q     <= byte_i[READ_B];
            phase_q  <= PH_DATA;
          end
          PH_DATA: begin
            if (read_q) begin
              if (!single_q) begin
                addr_q <= addr_q + AW'(1);
                rd_q   <= 1'b1;   // prefetch next register
              end
            end else begin
              wr_q    <= 1'b1;
              wdata_q <= byte_i;
            end
            if (single_q) phase_q <= PH_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_q;
  assign load_o      = rd_q;
  assign load_data_o = (addr_q == SEC_ADDR) ? (reg_rdata_i & SEC_MASK) : reg_rdata_i;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_o, reg_rd_o})) else $error("read and write together"); // R10
  AST_WR_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(byte_vld_i)) else $error("write without full byte"); // R9
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && !single_q && cs_i) |=> (addr_q == $past(addr_q) + AW'(1)))
    else $error("burst address not stepped"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (!reg_wr_o && !reg_rd_o)) else $error("strobe while idle"); // R1
endmodule

// File: rtl/spi_rtc_target.sv
module spi_rtc_target
  import spi_rtc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic              cs_s, sclk_s, mosi_s;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_d;
  logic              load;
  logic [BYTE_W-1:0] load_data;
  logic              miso_raw;

  spi_rtc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sclk_i, mosi_i}),
    .q_o    ({cs_s, sclk_s, mosi_s})
  );

  spi_rtc_shifter #(.DW(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_s),
    .sclk_i      (sclk_s),
    .mosi_i      (mosi_s),
    .load_i      (load),
    .load_data_i (load_data),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_d),
    .miso_o      (miso_raw)
  );

  spi_rtc_cmd #(.AW(ADDR_W), .DW(BYTE_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_s),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_d),
    .reg_addr_o  (reg_addr_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rd_o    (reg_rd_o),
    .reg_rdata_i (reg_rdata_i),
    .load_o      (load),
    .load_data_o (load_data)
  );

  assign miso_oe_o = cs_s;
  assign miso_o    = cs_s & miso_raw;

  AST_SEC_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o && reg_addr_o == '0) |=> !u_shift.tx_q[BYTE_W-1])
    else $error("seconds msb loaded"); // R8
endmodule

// File: tb/spi_rtc_target_tb.sv
module spi_rtc_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 0, rst_ni = 0, cs = 0, sclk = 0, mosi = 0;
  logic       miso_o, miso_oe_o, reg_wr_o, reg_rd_o;
  logic [3:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic [7:0] mem [16];
  logic [7:0] ref_mem [16];
  logic [7:0] tx_buf [24];
  logic [7:0] rx_buf [24];
  logic [11:0] exp_wr [$];
  logic [3:0]  exp_rd [$];
  int errors = 0, checks = 0, cs_low = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign reg_rdata_i = mem[reg_addr_o];

  spi_rtc_target u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .reg_addr_o(reg_addr_o),
    .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o), .reg_rd_o(reg_rd_o),
    .reg_rdata_i(reg_rdata_i)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock model comparison
  always @(negedge clk) begin
    if (rst_ni) begin
      cs_low = cs ? 0 : cs_low + 1;
      if (cs_low >= 4) chk("R1 idle outputs", {miso_oe_o, miso_o, reg_wr_o, reg_rd_o}, 0);
      if (reg_wr_o) begin
        if (exp_wr.size() == 0) chk("R4 unexpected write", {reg_addr_o, reg_wdata_o}, 16'hffff);
        else chk("R6 write strobe", {reg_addr_o, reg_wdata_o}, exp_wr.pop_front());
        mem[reg_addr_o] = reg_wdata_o;
      end
      if (reg_rd_o) begin
        if (exp_rd.size() == 0) chk("R10 unexpected read", reg_addr_o, 16'hffff);
        else chk("R10 read strobe", reg_addr_o, exp_rd.pop_front());
      end
    end
  end

  task automatic spi_xfer(input int nbits);
    @(negedge clk) cs = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1;
      mosi = tx_buf[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      rx_buf[i/8][7-(i%8)] = miso_o;
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
    cs = 0;
    mosi = 0;
    repeat (8) @(negedge clk);
    chk("R9 pending writes", exp_wr.size(), 0);
    chk("R10 pending reads", exp_rd.size(), 0);
  endtask

  task automatic exp_write(input logic [3:0] a, input logic [7:0] d);
    exp_wr.push_back({a, d});
    ref_mem[a] = d;
  endtask

  function automatic logic [7:0] rd_val(input logic [3:0] a);
    return (a == 0) ? (ref_mem[a] & 8'h7f) : ref_mem[a];
  endfunction

  task automatic burst_read(input logic [3:0] a, input logic [1:0] lo, input int n);
    tx_buf[0] = {a, 2'b01, lo};
    for (int k = 0; k <= n; k++) exp_rd.push_back(4'(a + k));
    for (int k = 1; k <= n; k++) tx_buf[k] = 8'h00;
    spi_xfer((n + 1) * 8);
    chk("R11 command phase miso", rx_buf[0], 0);
    for (int k = 0; k < n; k++) chk("R7 R2 burst read data", rx_buf[k+1], rd_val(4'(a + k)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 29 + 5);
      ref_mem[i] = mem[i];
    end
    mem[0] = 8'hd7; ref_mem[0] = 8'hd7;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 reset state", {miso_oe_o, miso_o, reg_wr_o, reg_rd_o}, 0);

    // single write, trailing byte ignored
    tx_buf[0] = 8'h58; tx_buf[1] = 8'h3c; tx_buf[2] = 8'h77;
    exp_write(4'd5, 8'h3c);
    spi_xfer(24);
    chk("R4 single write stored", mem[5], 8'h3c);

    // single read with an extra byte
    tx_buf[0] = 8'h5c; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    exp_rd.push_back(4'd5);
    spi_xfer(24);
    chk("R11 command phase miso", rx_buf[0], 0);
    chk("R5 R2 single read data", rx_buf[1], 8'h3c);
    chk("R5 trailing byte zero", rx_buf[2], 0);

    // burst write across wrap
    tx_buf[0] = 8'he0; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'hb3;
    exp_write(4'd14, 8'h11); exp_write(4'd15, 8'h22); exp_write(4'd0, 8'hb3);
    spi_xfer(32);
    chk("R6 wrap write", mem[0], 8'hb3);

    // burst read across wrap, seconds masked
    burst_read(4'd14, 2'b00, 3);

    // single read of seconds
    tx_buf[0] = 8'h0c; tx_buf[1] = 8'h00;
    exp_rd.push_back(4'd0);
    spi_xfer(16);
    chk("R8 seconds msb", rx_buf[1], 8'h33);

    // abort mid data byte: no write
    tx_buf[0] = 8'h28; tx_buf[1] = 8'hff;
    spi_xfer(12);
    tx_buf[0] = 8'h2c; tx_buf[1] = 8'h00;
    exp_rd.push_back(4'd2);
    spi_xfer(16);
    chk("R9 aborted write kept old", rx_buf[1], ref_mem[2]);

    // abort mid command, then fresh burst write
    tx_buf[0] = 8'hf0;
    spi_xfer(3);
    tx_buf[0] = 8'h70; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02;
    exp_write(4'd7, 8'h01); exp_write(4'd8, 8'h02);
    spi_xfer(24);
    chk("R9 fresh command after abort", mem[8], 8'h02);

    // low mode bits ignored: 0x9b is a single write to 9
    tx_buf[0] = 8'h9b; tx_buf[1] = 8'h5a; tx_buf[2] = 8'h66;
    exp_write(4'd9, 8'h5a);
    spi_xfer(24);
    chk("R3 low mode bits ignored", mem[9], 8'h5a);

    // long burst read with low bits set, full wrap
    burst_read(4'd3, 2'b11, 17);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule